// File: doc/BRIEF.md
# Halt Wake-Up Controller

This block manages the halted state of a small 4-bit CPU core. A halt strobe comes from the instruction decoder together with a 4-bit operand. The strobe drops the CPU clock-enable and stores the operand as a wake mask. While the core sleeps, the block watches three sources: a key-input port level, the basic timer carry flag, and the interrupt request flags paired with their enable flags. Each source has its own mask bit. As soon as any enabled source is true, the block raises the clock-enable again and emits a one-cycle resume pulse. The core then continues with the instruction after the halt.

A mask of all zeros arms no source, so only a reset can end that halt. There are two kinds of reset: an asynchronous power-on reset, and a synchronous chip-enable reset request. Both force the core to run again without a resume pulse, because the normal reset sequence takes over. Peripheral state outside this block is not touched.

The key and interrupt request inputs cross into the clock domain through a two-flop synchronizer. The timer carry flag is already synchronous and is used directly. The wake decision is registered.

Top module: `halt_wake_top`

## Requirements
- R1: After power-on reset (rstPowerN low), cpuClkEn is 1 and resumePulse is 0. Asserting rstPowerN during a halt also forces cpuClkEn to 1.
- R2: A haltStrobe sampled while running sets cpuClkEn to 0 from the next clock edge. cpuClkEn stays 0 while no enabled wake source is true.
- R3: Mask bit 3 enables wake on the key port. When any keyPort bit goes high, cpuClkEn returns to 1 on the third rising edge after the change.
- R4: Mask bit 2 enables wake on timerCarry. cpuClkEn returns to 1 on the first rising edge at which timerCarry is sampled high.
- R5: Mask bit 0 enables wake on interrupts. Wake occurs when some index i has intReq[i] and intEn[i] both high, on the third rising edge after the request rises. A request whose enable is low does not wake.
- R6: Mask bit 1 is reserved and never causes a wake, even when every source is true.
- R7: When several mask bits are set, any single enabled source being true is enough to wake.
- R8: With mask 0000 the core stays halted whatever the sources do. A one-cycle ceResetReq then sets cpuClkEn to 1 with resumePulse held at 0.
- R9: On a source-based wake, resumePulse is high for exactly one cycle, in the same cycle in which cpuClkEn first returns to 1.
- R10: If an enabled source is already true when the halt strobe is taken, wake happens on the following clock edge.
- R11: The stored mask is cleared on wake or reset. A later halt uses only its own operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstPowerN | input | 1 | Asynchronous power-on reset, active low |
| ceResetReq | input | 1 | Synchronous chip-enable reset request, active high |
| haltStrobe | input | 1 | One-cycle halt request from the decoder |
| haltMask | input | 4 | Wake operand: bit 3 key, bit 2 timer, bit 1 reserved, bit 0 interrupt |
| keyPort | input | KEY_W | Asynchronous key-input port level |
| timerCarry | input | 1 | Basic timer carry flag (synchronous) |
| intReq | input | INT_W | Asynchronous interrupt request flags |
| intEn | input | INT_W | Interrupt enable flags (synchronous) |
| cpuClkEn | output | 1 | CPU clock-enable, 0 while halted |
| resumePulse | output | 1 | One-cycle pulse on a source-based wake |

## Verification
A wrong stored mask bit shows up within three cycles of the matching source going high. Either the core wakes from a source it should ignore, or it stays asleep past the expected edge. A mask that is not cleared after a wake shows up on the next halt, which then wakes from a stale source. A wrong synchronizer depth moves the wake edge by a whole cycle, so the bench counts edges exactly rather than only waiting for a wake. A reset path that leaks a resume pulse appears in the same cycle that cpuClkEn returns.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;
  localparam int MASK_W  = 4;
  localparam int KEY_BIT = 3;
  localparam int TMR_BIT = 2;
  localparam int RSV_BIT = 1;
  localparam int IRQ_BIT = 0;

  typedef struct packed {
    logic loadMask;
    logic clearMask;
  } halt_ctrl_t;
endpackage

// File: rtl/halt_wake_sync.sv
module halt_wake_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/halt_wake_dp.sv
module halt_wake_dp
  import halt_wake_pkg::*;
#(
  parameter int KEY_W       = 4,
  parameter int INT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  halt_ctrl_t        ctrl,
  input  logic [MASK_W-1:0] haltMask,
  input  logic [KEY_W-1:0]  keyPort,
  input  logic              timerCarry,
  input  logic [INT_W-1:0]  intReq,
  input  logic [INT_W-1:0]  intEn,
  output logic              wakeHit,
  output logic [MASK_W-1:0] maskQ
);
  logic [KEY_W-1:0]  keySync;
  logic [INT_W-1:0]  reqSync;
  logic [MASK_W-1:0] srcVec;

  halt_wake_sync #(.W(KEY_W), .STAGES(SYNC_STAGES)) u_keySync (
    .clk(clk), .rstN(rstN), .d(keyPort), .q(keySync)
  );

  halt_wake_sync #(.W(INT_W), .STAGES(SYNC_STAGES)) u_reqSync (
    .clk(clk), .rstN(rstN), .d(intReq), .q(reqSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskQ <= '0;
    else if (ctrl.clearMask) maskQ <= '0;
    else if (ctrl.loadMask)  maskQ <= haltMask;
  end

  always_comb begin
    srcVec          = '0;
    srcVec[KEY_BIT] = |keySync;
    srcVec[TMR_BIT] = timerCarry;
    srcVec[RSV_BIT] = 1'b0;
    srcVec[IRQ_BIT] = |(reqSync & intEn);
    wakeHit         = |(maskQ & srcVec);
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_wake_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceResetReq,
  input  logic       haltStrobe,
  input  logic       wakeHit,
  output halt_ctrl_t ctrl,
  output logic       cpuClkEn,
  output logic       resumePulse
);
  logic haltedQ;
  logic resumeQ;
  logic enterHalt;
  logic leaveHalt;

  always_comb begin
    enterHalt      = haltStrobe && !haltedQ;
    leaveHalt      = haltedQ && wakeHit;
    ctrl.loadMask  = enterHalt && !ceResetReq;
    ctrl.clearMask = leaveHalt || ceResetReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      haltedQ <= 1'b0;
      resumeQ <= 1'b0;
    end else if (ceResetReq) begin
      haltedQ <= 1'b0;
      resumeQ <= 1'b0;
    end else begin
      resumeQ <= leaveHalt;
      if (enterHalt)      haltedQ <= 1'b1;
      else if (leaveHalt) haltedQ <= 1'b0;
    end
  end

  assign cpuClkEn    = !haltedQ;
  assign resumePulse = resumeQ;
endmodule

// File: rtl/halt_wake_top.sv
module halt_wake_top
  import halt_wake_pkg::*;
#(
  parameter int KEY_W       = 4,
  parameter int INT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstPowerN,
  input  logic              ceResetReq,
  input  logic              haltStrobe,
  input  logic [MASK_W-1:0] haltMask,
  input  logic [KEY_W-1:0]  keyPort,
  input  logic              timerCarry,
  input  logic [INT_W-1:0]  intReq,
  input  logic [INT_W-1:0]  intEn,
  output logic              cpuClkEn,
  output logic              resumePulse
);
  halt_ctrl_t        ctrl;
  logic              wakeHit;
  logic [MASK_W-1:0] maskQ;

  halt_wake_ctrl u_ctrl (
    .clk(clk), .rstN(rstPowerN), .ceResetReq(ceResetReq),
    .haltStrobe(haltStrobe), .wakeHit(wakeHit), .ctrl(ctrl),
    .cpuClkEn(cpuClkEn), .resumePulse(resumePulse)
  );

  halt_wake_dp #(.KEY_W(KEY_W), .INT_W(INT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstPowerN), .ctrl(ctrl), .haltMask(haltMask),
    .keyPort(keyPort), .timerCarry(timerCarry), .intReq(intReq),
    .intEn(intEn), .wakeHit(wakeHit), .maskQ(maskQ)
  );
endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk (
  input logic       clk,
  input logic       rstPowerN,
  input logic       ceResetReq,
  input logic       haltStrobe,
  input logic       timerCarry,
  input logic       cpuClkEn,
  input logic       resumePulse,
  input logic [3:0] maskQ
);
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rstPowerN)
    (haltStrobe && cpuClkEn && !ceResetReq) |=> !cpuClkEn); // R2

  AST_TIMER_WAKE: assert property (@(posedge clk) disable iff (!rstPowerN)
    (!cpuClkEn && maskQ[2] && timerCarry && !ceResetReq) |=> (cpuClkEn && resumePulse)); // R4

  AST_RSV_NO_WAKE: assert property (@(posedge clk) disable iff (!rstPowerN)
    (!cpuClkEn && maskQ == 4'b0010 && !ceResetReq) |=> !cpuClkEn); // R6

  AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstPowerN)
    (!cpuClkEn && maskQ == 4'b0000 && !ceResetReq) |=> !cpuClkEn); // R8

  AST_CE_RESET_RUN: assert property (@(posedge clk) disable iff (!rstPowerN)
    ceResetReq |=> (cpuClkEn && !resumePulse)); // R8

  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rstPowerN)
    resumePulse |=> !resumePulse); // R9

  AST_RESUME_ON_RISE: assert property (@(posedge clk) disable iff (!rstPowerN)
    resumePulse |-> (cpuClkEn && !$past(cpuClkEn))); // R9

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rstPowerN)
    $rose(cpuClkEn) |-> (maskQ == 4'b0000)); // R11
endmodule

bind halt_wake_top halt_wake_chk u_chk (
  .clk(clk), .rstPowerN(rstPowerN), .ceResetReq(ceResetReq),
  .haltStrobe(haltStrobe), .timerCarry(timerCarry), .cpuClkEn(cpuClkEn),
  .resumePulse(resumePulse), .maskQ(maskQ)
);

// File: tb/halt_wake_top_tb.sv
module halt_wake_top_tb;
  logic       clk = 1'b0;
  logic       rstPowerN = 1'b0;
  logic       ceResetReq = 1'b0;
  logic       haltStrobe = 1'b0;
  logic [3:0] haltMask = '0;
  logic [3:0] keyPort = '0;
  logic       timerCarry = 1'b0;
  logic [3:0] intReq = '0;
  logic [3:0] intEn = '0;
  logic       cpuClkEn;
  logic       resumePulse;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  halt_wake_top u_dut (
    .clk(clk), .rstPowerN(rstPowerN), .ceResetReq(ceResetReq),
    .haltStrobe(haltStrobe), .haltMask(haltMask), .keyPort(keyPort),
    .timerCarry(timerCarry), .intReq(intReq), .intEn(intEn),
    .cpuClkEn(cpuClkEn), .resumePulse(resumePulse)
  );

  // Vector fields: mask[19:16] key[15:12] timer[11] req[10:7] en[6:3] wakeEdge[2:0] (0 = none)
  localparam int NVEC = 11;
  localparam logic [19:0] VEC [NVEC] = '{
    {4'b1000, 4'b0001, 1'b0, 4'b0000, 4'b0000, 3'd3},  // R3 key wakes
    {4'b1000, 4'b0000, 1'b1, 4'b0000, 4'b0000, 3'd0},  // R3 timer not armed
    {4'b0100, 4'b0000, 1'b1, 4'b0000, 4'b0000, 3'd1},  // R4 timer wakes
    {4'b0100, 4'b1111, 1'b0, 4'b0000, 4'b0000, 3'd0},  // R4 key not armed
    {4'b0001, 4'b0000, 1'b0, 4'b0010, 4'b0010, 3'd3},  // R5 matched pair
    {4'b0001, 4'b0000, 1'b0, 4'b0010, 4'b0100, 3'd0},  // R5 mismatched pair
    {4'b0010, 4'b1111, 1'b1, 4'b1111, 4'b1111, 3'd0},  // R6 reserved bit
    {4'b1101, 4'b0000, 1'b1, 4'b0000, 4'b0000, 3'd1},  // R7 timer among several
    {4'b1101, 4'b0100, 1'b0, 4'b0000, 4'b0000, 3'd3},  // R7 key among several
    {4'b0000, 4'b1111, 1'b1, 4'b1111, 4'b1111, 3'd0},  // R8 empty mask
    {4'b1111, 4'b1000, 1'b1, 4'b0000, 4'b0000, 3'd1}   // R7 earliest source wins
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearSources();
    keyPort = '0; timerCarry = 1'b0; intReq = '0; intEn = '0;
  endtask

  task automatic issueHalt(input logic [3:0] m);
    @(negedge clk);
    haltStrobe = 1'b1;
    haltMask   = m;
    @(negedge clk);
    haltStrobe = 1'b0;
    haltMask   = '0;
  endtask

  task automatic ceReset();
    ceResetReq = 1'b1;
    @(negedge clk);
    ceResetReq = 1'b0;
  endtask

  task automatic runVec(input int idx);
    logic [19:0] v;
    int          gotEdge;
    logic        gotPulse;
    string       tag;
    v = VEC[idx];
    tag = $sformatf("vec%0d", idx);
    clearSources();
    repeat (3) @(negedge clk);
    issueHalt(v[19:16]);
    check("R2", {tag, " halted"}, cpuClkEn, 1'b0);
    keyPort = v[15:12]; timerCarry = v[11]; intReq = v[10:7]; intEn = v[6:3];
    gotEdge = 0; gotPulse = 1'b0;
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      if (gotEdge == 0 && cpuClkEn) begin
        gotEdge  = n;
        gotPulse = resumePulse;
      end
    end
    check("R7", {tag, " wake edge"}, gotEdge, {29'd0, v[2:0]});
    if (v[2:0] != 3'd0)
      check("R9", {tag, " resume with wake"}, gotPulse, 1'b1);
    else begin
      ceReset();
      check("R8", {tag, " ce reset runs"}, cpuClkEn, 1'b1);
      check("R8", {tag, " ce reset no pulse"}, resumePulse, 1'b0);
    end
    clearSources();
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "clkEn in reset", cpuClkEn, 1'b1);
    check("R1", "pulse in reset", resumePulse, 1'b0);
    rstPowerN = 1'b1;
    @(negedge clk);
    check("R1", "clkEn after reset", cpuClkEn, 1'b1);

    for (int i = 0; i < NVEC; i++) runVec(i);

    // R2: halt holds while sources stay quiet
    issueHalt(4'b1101);
    repeat (5) @(negedge clk);
    check("R2", "quiet halt holds", cpuClkEn, 1'b0);
    ceReset();

    // R10: source already true when halting
    timerCarry = 1'b1;
    issueHalt(4'b0100);
    check("R10", "entry cycle halted", cpuClkEn, 1'b0);
    @(negedge clk);
    check("R10", "wake next edge", cpuClkEn, 1'b1);
    check("R9", "pulse on wake", resumePulse, 1'b1);
    @(negedge clk);
    check("R9", "pulse one cycle", resumePulse, 1'b0);
    clearSources();

    // R11: second halt ignores the previous mask
    issueHalt(4'b0100);
    timerCarry = 1'b1;
    @(negedge clk);
    check("R11", "first halt wakes", cpuClkEn, 1'b1);
    issueHalt(4'b1000);
    repeat (4) @(negedge clk);
    check("R11", "stale timer bit ignored", cpuClkEn, 1'b0);
    keyPort = 4'b0010;
    repeat (2) @(negedge clk);
    check("R3", "key not yet through sync", cpuClkEn, 1'b0);
    @(negedge clk);
    check("R3", "key wake third edge", cpuClkEn, 1'b1);
    clearSources();

    // R1: power-on reset ends a halt
    issueHalt(4'b0000);
    check("R8", "empty mask halted", cpuClkEn, 1'b0);
    rstPowerN = 1'b0;
    #1;
    check("R1", "por forces run", cpuClkEn, 1'b1);
    check("R1", "por no pulse", resumePulse, 1'b0);
    @(negedge clk);
    rstPowerN = 1'b1;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule